// File: doc/BRIEF.md
# Triggered Prescaled Timer Counter

This block is the time base of a timer: a counter of configurable width that advances on a divided count event and wraps at a programmable modulo value. The count event can come from the core clock, from a synchronised external clock pin, or from rising edges of a trigger input. A power-of-two prescaler, selected by a small code, divides whichever event source is active.

The trigger input can also control the counter. It can hold the counter off until the first active edge, restart it after it has stopped itself on overflow, force it back to zero, or freeze it while the trigger is active. The counter can count upward only, with edge-aligned wrap, or it can count up to the modulo value and back down to zero. Every overflow sets a sticky flag. That flag records whether the overflow happened at the top or the bottom of the count, and it drives an interrupt request when enabled.

Top module: `tmr_base`

## Requirements
- R1: With prescale code c (3 bits) the counter advances once per 2^c count events, so codes 0..7 divide by 1..128.
- R2: Clock-select code 0 disables the counter and holds its value. Code 1 uses every clock as an event. Code 2 uses rising edges of `ext_clk_i` after a two-stage synchroniser. Code 3 uses rising edges of the active trigger.
- R3: With `cfg_updown_i`=0 the counter counts up. An advance while the count is at or above `modulo_i` sets it to 0 and is an overflow at the top (`ovf_top_o`=1).
- R4: With `cfg_updown_i`=1 the counter rises to `modulo_i` and then falls to 0. Leaving the modulo value downward is a top overflow (`ovf_top_o`=1). Leaving 0 upward is a bottom overflow (`ovf_top_o`=0).
- R5: With `cfg_start_trig_i`=1 no counting happens after enable until an active trigger rising edge. Counting begins on the clock after that edge.
- R6: With `cfg_stop_ovf_i`=1 the counter stops after an overflow and stays stopped until the next active trigger rising edge.
- R7: With `cfg_reload_trig_i`=1 an active trigger rising edge sets the counter to 0 and clears the prescaler. This takes priority over counting.
- R8: With `cfg_pause_trig_i`=1 the count holds while the trigger is active and resumes when the trigger goes inactive.
- R9: `cfg_trig_inv_i`=0 makes a high trigger active. `cfg_trig_inv_i`=1 makes a low trigger active.
- R10: `ovf_flag_o` is set by an overflow and cleared by `ovf_clr_i`=1. If an overflow occurs in the same cycle as a clear, the flag stays set.
- R11: `irq_o` is 1 exactly when `ovf_flag_o` and `cfg_ovf_ie_i` are both 1.
- R12: Any change of the clock-select code clears the prescaler divider. No advance happens in the cycle of the change.
- R13: During reset the count, the overflow flag, the top/bottom indicator and the interrupt request are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| trig_i | input | 1 | Trigger input, synchronous to clk |
| cfg_psc_i | input | 3 | Prescale code |
| cfg_clksel_i | input | 2 | Event source select |
| cfg_updown_i | input | 1 | 0 up counting, 1 up-down counting |
| cfg_start_trig_i | input | 1 | Wait for trigger edge before counting |
| cfg_stop_ovf_i | input | 1 | Stop after overflow |
| cfg_reload_trig_i | input | 1 | Trigger edge reloads counter to 0 |
| cfg_pause_trig_i | input | 1 | Active trigger pauses counting |
| cfg_trig_inv_i | input | 1 | Trigger active low when 1 |
| cfg_ovf_ie_i | input | 1 | Overflow interrupt enable |
| modulo_i | input | 16 | Wrap value |
| ovf_clr_i | input | 1 | Clear overflow flag |
| count_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_top_o | output | 1 | Last overflow was at the top |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench targets the points where a timer is easy to get off by one cycle or one period.

- It checks prescaled counts across several divide ratios in both counting directions. A divider that reset on the wrong event, or an up-down turn that repeated the modulo value, would show up as a wrong count or a wrong top/bottom indicator.
- It checks trigger-controlled start, restart after a self-stop, reload and pause under both polarities. A design that let the counter run before the first edge, or advanced during the cycle of a pause, would end on a different count.
- It checks a clear arriving together with an overflow. A design that gave the clear priority would drop the flag while overflows keep occurring.
- It checks a clock-source change in the middle of a prescale period. A divider that was not cleared on the change would tick about three cycles early.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      CLK_OFF  = 2'd0,
      CLK_CORE = 2'd1,
      CLK_EXT  = 2'd2,
      CLK_TRIG = 2'd3
   } clk_sel_e;

   typedef struct packed {
      logic start_on_trig;
      logic stop_on_ovf;
      logic reload_on_trig;
      logic pause_on_trig;
   } trig_ctl_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o
);

   initial assert (STAGES >= 0 && STAGES <= 4) else $error("STAGES out of range");

   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl_o = d_i;
      end else begin : g_sync
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q[0] <= 1'b0;
            else        sr_q[0] <= d_i;
         end
         for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sr_q[i] <= 1'b0;
               else        sr_q[i] <= sr_q[i-1];
            end
         end
         assign lvl_o = sr_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev_q;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_pkg::*;
#(
   parameter int PSC_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] code_i,
   input  clk_sel_e         mode_i,
   input  logic             evt_i,
   input  logic             adv_i,
   input  logic             clr_i,
   output logic             tick_o
);

   localparam int DIV_W = (1 << PSC_W) - 1;

   initial assert (PSC_W >= 1 && PSC_W <= 4) else $error("PSC_W out of range");

   clk_sel_e         mode_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;
   logic             mode_chg;

   assign mask     = ~({DIV_W{1'b1}} << code_i);
   assign mode_chg = (mode_i != mode_q);
   assign tick_o   = evt_i & adv_i & ~mode_chg & ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= CLK_OFF;
         div_q  <= '0;
      end else begin
         mode_q <= mode_i;
         if (mode_chg || clr_i)  div_q <= '0;
         else if (evt_i && adv_i) div_q <= div_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl
   import tmr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      enable_i,
   input  trig_ctl_t ctl_i,
   input  logic      trig_lvl_i,
   input  logic      trig_rise_i,
   input  logic      ovf_i,
   output logic      go_o
);

   logic armed_q;
   logic stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         stop_q  <= 1'b0;
      end else if (!enable_i) begin
         armed_q <= 1'b0;
         stop_q  <= 1'b0;
      end else begin
         if (trig_rise_i) armed_q <= 1'b1;
         if (trig_rise_i)                       stop_q <= 1'b0;
         else if (ovf_i && ctl_i.stop_on_ovf)   stop_q <= 1'b1;
      end
   end

   assign go_o = enable_i
               & (~ctl_i.start_on_trig | armed_q)
               & ~(stop_q & ctl_i.stop_on_ovf)
               & ~(ctl_i.pause_on_trig & trig_lvl_i);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             reload_i,
   input  logic             updown_i,
   input  logic [CNT_W-1:0] modulo_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o,
   output logic             ovf_top_o
);

   initial assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             up_q, up_d;
   logic             at_top, mod_zero;

   assign at_top   = (cnt_q >= modulo_i);
   assign mod_zero = (modulo_i == '0);

   always_comb begin
      cnt_d     = cnt_q;
      up_d      = up_q;
      ovf_o     = 1'b0;
      ovf_top_o = 1'b0;
      if (reload_i) begin
         cnt_d = '0;
         up_d  = 1'b1;
      end else if (tick_i) begin
         if (!updown_i) begin
            up_d = 1'b1;
            if (at_top) begin
               cnt_d     = '0;
               ovf_o     = 1'b1;
               ovf_top_o = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end else if (up_q) begin
            if (at_top) begin
               ovf_o     = 1'b1;
               ovf_top_o = 1'b1;
               cnt_d     = mod_zero ? '0 : modulo_i - CNT_W'(1);
               up_d      = mod_zero;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end else begin
            if (cnt_q == '0) begin
               ovf_o = 1'b1;
               cnt_d = mod_zero ? '0 : CNT_W'(1);
               up_d  = 1'b1;
            end else begin
               cnt_d = cnt_q - CNT_W'(1);
            end
         end
      end else if (!updown_i) begin
         up_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_d;
         up_q  <= up_d;
      end
   end

   assign count_o = cnt_q;

endmodule

// File: rtl/tmr_base.sv
module tmr_base
   import tmr_pkg::*;
#(
   parameter int CNT_W           = 16,
   parameter int PSC_W           = 3,
   parameter int EXT_SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_i,
   input  logic             trig_i,
   input  logic [PSC_W-1:0] cfg_psc_i,
   input  logic [1:0]       cfg_clksel_i,
   input  logic             cfg_updown_i,
   input  logic             cfg_start_trig_i,
   input  logic             cfg_stop_ovf_i,
   input  logic             cfg_reload_trig_i,
   input  logic             cfg_pause_trig_i,
   input  logic             cfg_trig_inv_i,
   input  logic             cfg_ovf_ie_i,
   input  logic [CNT_W-1:0] modulo_i,
   input  logic             ovf_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_flag_o,
   output logic             ovf_top_o,
   output logic             irq_o
);

   initial assert (EXT_SYNC_STAGES >= 1) else $error("external clock needs a synchroniser");

   clk_sel_e  mode;
   trig_ctl_t ctl;
   logic      trig_lvl, trig_rise, ext_lvl, ext_rise;
   logic      enable, evt, go, tick, reload;
   logic      core_ovf, core_top;
   logic      flag_q, top_q;

   assign mode = clk_sel_e'(cfg_clksel_i);
   assign ctl  = '{start_on_trig:  cfg_start_trig_i,
                   stop_on_ovf:    cfg_stop_ovf_i,
                   reload_on_trig: cfg_reload_trig_i,
                   pause_on_trig:  cfg_pause_trig_i};

   tmr_edge_sync #(.STAGES(0)) u_trig_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (trig_i ^ cfg_trig_inv_i),
      .lvl_o  (trig_lvl),
      .rise_o (trig_rise)
   );

   tmr_edge_sync #(.STAGES(EXT_SYNC_STAGES)) u_ext_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (ext_clk_i),
      .lvl_o  (ext_lvl),
      .rise_o (ext_rise)
   );

   assign enable = (mode != CLK_OFF);
   assign reload = enable & ctl.reload_on_trig & trig_rise;

   always_comb begin
      unique case (mode)
         CLK_CORE: evt = 1'b1;
         CLK_EXT:  evt = ext_rise & ext_lvl;
         CLK_TRIG: evt = trig_rise;
         default:  evt = 1'b0;
      endcase
   end

   tmr_run_ctl u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable),
      .ctl_i       (ctl),
      .trig_lvl_i  (trig_lvl),
      .trig_rise_i (trig_rise),
      .ovf_i       (core_ovf),
      .go_o        (go)
   );

   tmr_prescale #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (cfg_psc_i),
      .mode_i (mode),
      .evt_i  (evt),
      .adv_i  (go),
      .clr_i  (reload),
      .tick_o (tick)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .reload_i  (reload),
      .updown_i  (cfg_updown_i),
      .modulo_i  (modulo_i),
      .count_o   (count_o),
      .ovf_o     (core_ovf),
      .ovf_top_o (core_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         top_q  <= 1'b0;
      end else if (core_ovf) begin
         flag_q <= 1'b1;
         top_q  <= core_top;
      end else if (ovf_clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign ovf_flag_o = flag_q;
   assign ovf_top_o  = top_q;
   assign irq_o      = flag_q & cfg_ovf_ie_i;

endmodule

// File: rtl/tmr_base_chk.sv
module tmr_base_chk #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             trig_i,
   input logic [1:0]       cfg_clksel_i,
   input logic             cfg_updown_i,
   input logic             cfg_reload_trig_i,
   input logic             cfg_pause_trig_i,
   input logic             cfg_trig_inv_i,
   input logic             ovf_clr_i,
   input logic [CNT_W-1:0] count_o,
   input logic             ovf_flag_o,
   input logic             irq_o
);

   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_clksel_i == 2'd0) |=> $stable(count_o)); // R2

   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_updown_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + CNT_W'(1)
                         || count_o == '0)); // R3

   AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pause_trig_i && (trig_i ^ cfg_trig_inv_i) && !cfg_reload_trig_i) |=> $stable(count_o)); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o); // R10

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ovf_flag_o); // R11

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (count_o == '0 && !ovf_flag_o && !irq_o)); // R13

endmodule

bind tmr_base tmr_base_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/tmr_base_tb.sv
`timescale 1ns/1ps
module tmr_base_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk_i = 1'b0;
   logic        trig_i = 1'b0;
   logic [2:0]  cfg_psc_i = '0;
   logic [1:0]  cfg_clksel_i = '0;
   logic        cfg_updown_i = 1'b0;
   logic        cfg_start_trig_i = 1'b0;
   logic        cfg_stop_ovf_i = 1'b0;
   logic        cfg_reload_trig_i = 1'b0;
   logic        cfg_pause_trig_i = 1'b0;
   logic        cfg_trig_inv_i = 1'b0;
   logic        cfg_ovf_ie_i = 1'b1;
   logic [15:0] modulo_i = '0;
   logic        ovf_clr_i = 1'b0;
   logic [15:0] count_o;
   logic        ovf_flag_o, ovf_top_o, irq_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   tmr_base u_dut (.*);

   // {psc[35:33], updown[32], modulo[31:16], cycles[15:0]}
   localparam int NVEC = 7;
   localparam logic [35:0] VEC [NVEC] = '{
      {3'd0, 1'b0, 16'd9,   16'd25},
      {3'd1, 1'b0, 16'd5,   16'd30},
      {3'd3, 1'b0, 16'd100, 16'd50},
      {3'd0, 1'b1, 16'd4,   16'd12},
      {3'd2, 1'b1, 16'd3,   16'd40},
      {3'd7, 1'b0, 16'd2,   16'd300},
      {3'd0, 1'b0, 16'd0,   16'd5}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic restart();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic defaults();
      trig_i = 0; ext_clk_i = 0; cfg_psc_i = 0; cfg_clksel_i = 2'd1; cfg_updown_i = 0;
      cfg_start_trig_i = 0; cfg_stop_ovf_i = 0; cfg_reload_trig_i = 0;
      cfg_pause_trig_i = 0; cfg_trig_inv_i = 0; cfg_ovf_ie_i = 1; ovf_clr_i = 0;
   endtask

   // expected after n clocks from release; first clock lost to the source change
   function automatic void model(input int psc, input int upd, input int md, input int n,
                                 output int cnt, output int flag, output int top);
      int ticks, k;
      ticks = (n - 1) >> psc;
      flag  = (ticks >= md + 1) ? 1 : 0;
      if (upd == 0) begin
         cnt = ticks % (md + 1);
         top = flag;
      end else begin
         k   = ticks % (2 * md);
         cnt = (k <= md) ? k : 2 * md - k;
         top = flag ? (((ticks - 1) / md) % 2) : 0;
      end
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int ec, ef, et;
      // R13 reset state
      defaults();
      modulo_i = 16'd5;
      repeat (3) @(negedge clk);
      chk("R13 count", count_o, 0);
      chk("R13 flag", ovf_flag_o, 0);
      chk("R13 top", ovf_top_o, 0);
      chk("R13 irq", irq_o, 0);

      // vector table: R1 R3 R4 R11
      for (int v = 0; v < NVEC; v++) begin
         defaults();
         cfg_psc_i    = VEC[v][35:33];
         cfg_updown_i = VEC[v][32];
         modulo_i     = VEC[v][31:16];
         restart();
         repeat (int'(VEC[v][15:0])) @(negedge clk);
         model(int'(VEC[v][35:33]), int'(VEC[v][32]), int'(VEC[v][31:16]),
               int'(VEC[v][15:0]), ec, ef, et);
         chk($sformatf("R1/R3/R4 count vec%0d", v), count_o, ec);
         chk($sformatf("R3/R4 flag vec%0d", v), ovf_flag_o, ef);
         chk($sformatf("R4 top vec%0d", v), ovf_top_o, et);
         chk($sformatf("R11 irq vec%0d", v), irq_o, ef);
      end

      // R2 disabled holds
      defaults(); modulo_i = 16'd100;
      restart();
      repeat (8) @(negedge clk);
      chk("R2 run", count_o, 7);
      cfg_clksel_i = 2'd0;
      repeat (10) @(negedge clk);
      chk("R2 disabled hold", count_o, 7);

      // R2 external clock source
      defaults(); cfg_clksel_i = 2'd2; modulo_i = 16'd100;
      restart();
      repeat (5) begin
         ext_clk_i = 1; repeat (2) @(negedge clk);
         ext_clk_i = 0; repeat (2) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk("R2 ext edges", count_o, 5);

      // R2 trigger edges as source
      defaults(); cfg_clksel_i = 2'd3; modulo_i = 16'd100;
      restart();
      repeat (2) @(negedge clk);
      repeat (4) begin
         trig_i = 1; @(negedge clk);
         trig_i = 0; repeat (2) @(negedge clk);
      end
      chk("R2 trigger edges", count_o, 4);

      // R5 start on trigger
      defaults(); cfg_start_trig_i = 1; modulo_i = 16'd100;
      restart();
      repeat (10) @(negedge clk);
      chk("R5 waits", count_o, 0);
      trig_i = 1; @(negedge clk); trig_i = 0;
      repeat (10) @(negedge clk);
      chk("R5 started", count_o, 10);

      // R6 stop on overflow
      defaults(); cfg_stop_ovf_i = 1; modulo_i = 16'd3;
      restart();
      repeat (20) @(negedge clk);
      chk("R6 stopped", count_o, 0);
      chk("R6 flag", ovf_flag_o, 1);
      trig_i = 1; @(negedge clk); trig_i = 0;
      repeat (2) @(negedge clk);
      chk("R6 restart", count_o, 2);

      // R7 reload
      defaults(); cfg_reload_trig_i = 1; modulo_i = 16'd100;
      restart();
      repeat (20) @(negedge clk);
      chk("R7 before", count_o, 19);
      trig_i = 1; @(negedge clk);
      chk("R7 reloaded", count_o, 0);
      trig_i = 0; @(negedge clk);
      chk("R7 after", count_o, 1);

      // R8 pause
      defaults(); cfg_pause_trig_i = 1; modulo_i = 16'd100;
      restart();
      repeat (10) @(negedge clk);
      trig_i = 1; repeat (5) @(negedge clk);
      chk("R8 paused", count_o, 9);
      trig_i = 0; repeat (3) @(negedge clk);
      chk("R8 resumed", count_o, 12);

      // R9 inverted polarity
      defaults(); cfg_pause_trig_i = 1; cfg_trig_inv_i = 1; trig_i = 1; modulo_i = 16'd100;
      restart();
      repeat (10) @(negedge clk);
      chk("R9 high inactive", count_o, 9);
      trig_i = 0; repeat (4) @(negedge clk);
      chk("R9 low active", count_o, 9);
      trig_i = 1; repeat (2) @(negedge clk);
      chk("R9 released", count_o, 11);

      // R10 clear, then overflow beats clear
      defaults(); modulo_i = 16'd3;
      restart();
      repeat (6) @(negedge clk);
      chk("R10 set", ovf_flag_o, 1);
      ovf_clr_i = 1; @(negedge clk); ovf_clr_i = 0;
      chk("R10 cleared", ovf_flag_o, 0);
      defaults(); modulo_i = 16'd0;
      restart();
      repeat (3) @(negedge clk);
      ovf_clr_i = 1; repeat (3) @(negedge clk);
      chk("R10 priority", ovf_flag_o, 1);
      // R11 enable gating
      cfg_ovf_ie_i = 0; #0.5;
      chk("R11 masked", irq_o, 0);
      cfg_ovf_ie_i = 1; #0.5;
      chk("R11 enabled", irq_o, 1);
      ovf_clr_i = 0;

      // R12 divider cleared on source change
      defaults(); cfg_psc_i = 3'd2; modulo_i = 16'd100;
      restart();
      repeat (4) @(negedge clk);
      chk("R12 partial", count_o, 0);
      cfg_clksel_i = 2'd2; @(negedge clk);
      cfg_clksel_i = 2'd1; @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R12 no early tick", count_o, 0);
      @(negedge clk);
      chk("R12 full period", count_o, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule